// File: doc/BRIEF.md
# Configuration clock pulse burst generator

This peripheral produces a counted burst of configuration clock pulses on a single output pin and reports when the burst has finished. Software sees two 32-bit registers on a simple single-cycle register bus. Writing a number N to the count register starts a burst of exactly N pulses. Each pulse is high for `DIV` input clock cycles and then low for `DIV` input clock cycles.

When the low phase of the final pulse ends, a sticky done flag is raised in the status register. Software clears it by writing a 1 to bit 0. While a burst runs, a busy flag is visible in the status register, and further writes to the count register are dropped. A typical use is to supply the configuration logic with a fixed number of clocks between control steps: 0x100 pulses before a request, and 0x7FF pulses after it.

Bus timing: a cycle with `bus_sel` high is one access. A write (`bus_wr` high) takes effect at that clock edge. Read data appears on `bus_rdata` after that edge and shows the register state from before the edge.

Top module: `cfg_pulse_burst`

## Requirements
- R1: After reset, `dclk_o` is low, the status register (byte offset 0x0C) reads 0 and the count register (byte offset 0x08) reads 0.
- R2: A write of N to offset 0x08 while idle produces exactly N rising edges on `dclk_o`.
- R3: `dclk_o` goes high on the edge that takes the count write. Every pulse is then high for exactly `DIV` clock cycles and low for exactly `DIV` clock cycles, with no gap between pulses.
- R4: Status bit 0 (done) is set on the clock edge where the last low phase ends, which is 2·`DIV`·N edges after the count write. After a cleared start it then reads exactly 1.
- R5: Status bit 1 (busy) reads 1 from the edge of the count write until the edge that sets done, and `dclk_o` is never high while busy is 0.
- R6: A write to offset 0x0C with bit 0 set clears done. A write with bit 0 clear leaves done unchanged.
- R7: Done stays set until it is cleared, including while a new burst runs, when status reads 3.
- R8: A count of 0 sets done on the edge of the write and produces no pulse.
- R9: A count write while busy is ignored: the pulse count, the completion time and the count readback are unchanged.
- R10: Reads from any offset other than 0x08 and 0x0C return 0. Writes to those offsets have no effect on the pulses, on status or on the count.
- R11: Any count from 0 to 2^`CNT_W`−1 is accepted (0x7FF and 0xFFF with the default width), and the count register reads back the last accepted value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock; pulses are derived from it |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Access strobe, one access per cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the access |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, registered |
| dclk_o | output | 1 | Configuration clock pulse output |

## Verification
The bench runs bursts for every count from 0 to 16 and for 0x100, 0x7FF and 0xFFF, with an odd divide ratio so that half-period errors are visible. It counts rising edges, high-run lengths and low-run lengths on the pin, and reads status one edge before and exactly at the expected completion edge. The small counts separate off-by-one errors in the pulse count from errors in the phase counter. The large counts show that the full counter width is used. Further patterns cover clearing status with bit 0 set and with bit 0 clear, starting a burst without clearing done, a count write in the middle of a burst, and accesses to unused offsets; each of these distinguishes a missing gate from a correct one at the pins.

// File: rtl/cpb_pkg.sv
`timescale 1ns/1ps
package cpb_pkg;
    // Byte offsets decoded by the register slice
    localparam int OFF_COUNT  = 'h08;
    localparam int OFF_STATUS = 'h0C;

    // Status bit positions
    localparam int STAT_DONE_BIT = 0;
    localparam int STAT_BUSY_BIT = 1;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HIGH = 2'd1,
        PH_LOW  = 2'd2
    } phase_e;
endpackage

// File: rtl/cpb_regif.sv
`timescale 1ns/1ps
module cpb_regif #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              busy_i,
    input  logic              done_i,
    output logic              start_o,
    output logic [CNT_W-1:0]  start_cnt_o,
    output logic              clr_o,
    output logic [DATA_W-1:0] rdata_o
);
    import cpb_pkg::*;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t cur_q, nxt_d;
    logic  hit_cnt, hit_stat;
    logic  unused_wdata_hi;

    assign unused_wdata_hi = ^wdata_i[DATA_W-1:CNT_W];

    always_comb begin
        nxt_d       = cur_q;
        start_o     = 1'b0;
        clr_o       = 1'b0;
        hit_cnt     = (addr_i == ADDR_W'(OFF_COUNT));
        hit_stat    = (addr_i == ADDR_W'(OFF_STATUS));
        start_cnt_o = wdata_i[CNT_W-1:0];
        if (sel_i && wr_i) begin
            if (hit_cnt && !busy_i) begin
                start_o     = 1'b1;
                nxt_d.count = wdata_i[CNT_W-1:0];
            end
            if (hit_stat && wdata_i[STAT_DONE_BIT]) begin
                clr_o = 1'b1;
            end
        end
        if (sel_i && !wr_i) begin
            if (hit_cnt) begin
                nxt_d.rdata = DATA_W'(cur_q.count);
            end else if (hit_stat) begin
                nxt_d.rdata = '0;
                nxt_d.rdata[STAT_DONE_BIT] = done_i;
                nxt_d.rdata[STAT_BUSY_BIT] = busy_i;
            end else begin
                nxt_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign rdata_o = cur_q.rdata;

    // R9: a count write during a burst leaves the stored count alone
    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && wr_i && hit_cnt && busy_i) |=> $stable(cur_q.count));

    // R10: a read of an unused offset returns zero
    p_unused_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && !hit_cnt && !hit_stat) |=> (rdata_o == '0));
endmodule

// File: rtl/cpb_pulse_gen.sv
`timescale 1ns/1ps
module cpb_pulse_gen #(
    parameter int CNT_W = 12,
    parameter int DIV   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic [CNT_W-1:0] count_i,
    output logic             dclk_o,
    output logic             busy_o,
    output logic             finish_o
);
    import cpb_pkg::*;

    localparam int              PH_W      = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PH_W-1:0] TICK_LAST = PH_W'(DIV - 1);

    typedef struct packed {
        phase_e           ph;
        logic [PH_W-1:0]  tick;
        logic [CNT_W-1:0] remain;
        logic             dclk;
    } gen_t;

    gen_t cur_q, nxt_d;

    always_comb begin
        nxt_d    = cur_q;
        finish_o = 1'b0;
        unique case (cur_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    if (count_i == '0) begin
                        finish_o = 1'b1;
                    end else begin
                        nxt_d.ph     = PH_HIGH;
                        nxt_d.tick   = '0;
                        nxt_d.remain = count_i;
                        nxt_d.dclk   = 1'b1;
                    end
                end
            end
            PH_HIGH: begin
                if (cur_q.tick == TICK_LAST) begin
                    nxt_d.ph   = PH_LOW;
                    nxt_d.tick = '0;
                    nxt_d.dclk = 1'b0;
                end else begin
                    nxt_d.tick = cur_q.tick + 1'b1;
                end
            end
            PH_LOW: begin
                if (cur_q.tick == TICK_LAST) begin
                    nxt_d.tick = '0;
                    if (cur_q.remain == CNT_W'(1)) begin
                        nxt_d.ph     = PH_IDLE;
                        nxt_d.remain = '0;
                        finish_o     = 1'b1;
                    end else begin
                        nxt_d.ph     = PH_HIGH;
                        nxt_d.remain = cur_q.remain - 1'b1;
                        nxt_d.dclk   = 1'b1;
                    end
                end else begin
                    nxt_d.tick = cur_q.tick + 1'b1;
                end
            end
            default: begin
                nxt_d = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign dclk_o = cur_q.dclk;
    assign busy_o = (cur_q.ph != PH_IDLE);

    // R3: the pin is quiet and nothing is pending while idle
    p_idle_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph == PH_IDLE) |-> (!cur_q.dclk && cur_q.remain == '0));

    // R3: the phase counter never passes the divide ratio
    p_tick_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.tick <= TICK_LAST);

    // R3: a pulse stays high for more than one cycle when DIV exceeds 1
    p_high_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && $rose(cur_q.dclk)) |=> cur_q.dclk);

    // R4: completion of a nonzero burst happens only at the end of a low phase
    p_finish_in_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o && !start_i) |-> (cur_q.ph == PH_LOW && !cur_q.dclk));

    // R2: an active burst always has at least one pulse outstanding
    p_remain_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.ph != PH_IDLE) |-> (cur_q.remain != '0));
endmodule

// File: rtl/cpb_status.sv
`timescale 1ns/1ps
module cpb_status (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic done_o
);
    typedef struct packed {
        logic done;
    } stat_t;

    stat_t cur_q, nxt_d;

    always_comb begin
        nxt_d = cur_q;
        if (set_i) begin
            nxt_d.done = 1'b1;
        end else if (clr_i) begin
            nxt_d.done = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign done_o = cur_q.done;

    // R4: completion always raises the flag on the next cycle
    p_set_raises_r4: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> done_o);

    // R7: the flag only falls on a clear request
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clr_i) |=> done_o);

    // R6: a clear without a coincident completion drops the flag
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !done_o);
endmodule

// File: rtl/cfg_pulse_burst.sv
`timescale 1ns/1ps
module cfg_pulse_burst #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 12,
    parameter int DIV    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              dclk_o
);
    logic             start;
    logic [CNT_W-1:0] start_cnt;
    logic             clr;
    logic             busy;
    logic             done;
    logic             finish;

    cpb_regif #(
        .ADDR_W(ADDR_W),
        .DATA_W(DATA_W),
        .CNT_W (CNT_W)
    ) u_regif (
        .clk        (clk),
        .rst_n      (rst_n),
        .sel_i      (bus_sel),
        .wr_i       (bus_wr),
        .addr_i     (bus_addr),
        .wdata_i    (bus_wdata),
        .busy_i     (busy),
        .done_i     (done),
        .start_o    (start),
        .start_cnt_o(start_cnt),
        .clr_o      (clr),
        .rdata_o    (bus_rdata)
    );

    cpb_pulse_gen #(
        .CNT_W(CNT_W),
        .DIV  (DIV)
    ) u_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .count_i (start_cnt),
        .dclk_o  (dclk_o),
        .busy_o  (busy),
        .finish_o(finish)
    );

    cpb_status u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (finish),
        .clr_i (clr),
        .done_o(done)
    );

    // R5: the pin only toggles inside a burst
    p_dclk_needs_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dclk_o |-> busy);

    // R8: a zero-count start completes without leaving idle
    p_zero_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && start_cnt == '0) |=> (!busy && done && !dclk_o));
endmodule

// File: tb/tb_cfg_pulse_burst.sv
`timescale 1ns/1ps
module tb_cfg_pulse_burst;
    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 12;
    localparam int DIV    = 3;
    localparam logic [ADDR_W-1:0] A_CNT  = 8'h08;
    localparam logic [ADDR_W-1:0] A_STAT = 8'h0C;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_sel = 1'b0;
    logic              bus_wr = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [DATA_W-1:0] bus_wdata = '0;
    logic [DATA_W-1:0] bus_rdata;
    logic              dclk_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // pin monitor state (written only by the monitor)
    int  rises = 0;
    int  highs = 0;
    int  bad_high = 0;
    int  bad_low = 0;
    int  run = 0;
    logic prev = 1'b0;

    cfg_pulse_burst #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV(DIV)
    ) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .dclk_o(dclk_o)
    );

    always #4 clk = ~clk;

    always @(negedge clk) begin
        if (dclk_o) begin
            if (!prev) begin
                rises = rises + 1;
                if (rises > 1 && run < DIV) bad_low = bad_low + 1;
                run = 0;
            end
            highs = highs + 1;
        end else if (prev) begin
            if (run != DIV) bad_high = bad_high + 1;
            run = 0;
        end
        run = run + 1;
        prev = dclk_o;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    task automatic expect_reg(input logic [ADDR_W-1:0] a, input longint exp, input string req);
        logic [DATA_W-1:0] v;
        bus_read(a, v);
        chk(v == exp, req, v, exp);
    endtask

    task automatic run_burst(input int n);
        int r0, h0, bh0, bl0;
        bus_write(A_STAT, 32'h1);
        expect_reg(A_STAT, 0, "R6 clear before start");
        r0 = rises; h0 = highs; bh0 = bad_high; bl0 = bad_low;
        bus_write(A_CNT, n);
        if (n == 0) begin
            expect_reg(A_STAT, 1, "R8 zero count done at once");
            repeat (4) @(negedge clk);
            chk(rises == r0, "R8 zero count no pulse", rises - r0, 0);
        end else begin
            repeat (2 * DIV * n - 1) @(negedge clk);
            expect_reg(A_STAT, 2, "R5 busy on last low cycle");
            expect_reg(A_STAT, 1, "R4 done on final edge");
            chk(rises - r0 == n, "R2 pulse count", rises - r0, n);
            chk(highs - h0 == DIV * n, "R3 high cycles", highs - h0, DIV * n);
            chk(bad_high == bh0 && bad_low == bl0, "R3 pulse shape",
                (bad_high - bh0) + (bad_low - bl0), 0);
        end
        expect_reg(A_CNT, n, "R11 count readback");
    endtask

    initial begin
        logic [DATA_W-1:0] v;
        int r0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk(dclk_o == 1'b0, "R1 dclk low", dclk_o, 0);
        expect_reg(A_STAT, 0, "R1 status");
        expect_reg(A_CNT, 0, "R1 count");

        // R10 unused offsets
        r0 = rises;
        bus_write(8'h10, 32'h5);
        bus_write(8'h04, 32'h7);
        bus_write(8'h0D, 32'h9);
        expect_reg(8'h10, 0, "R10 unused read 0x10");
        expect_reg(8'h04, 0, "R10 unused read 0x04");
        expect_reg(8'h00, 0, "R10 unused read 0x00");
        expect_reg(A_STAT, 0, "R10 status untouched");
        expect_reg(A_CNT, 0, "R10 count untouched");
        repeat (10) @(negedge clk);
        chk(rises == r0, "R10 no pulses", rises - r0, 0);

        // R2 R3 R4 R5 R8 R11 sweep
        for (int n = 0; n <= 16; n++) run_burst(n);
        run_burst(12'h100);
        run_burst(12'h7FF);
        run_burst(12'hFFF);

        // R6 clear semantics (done is 1 now)
        bus_write(A_STAT, 32'h0);
        expect_reg(A_STAT, 1, "R6 bit0 clear ignored");
        bus_write(A_STAT, 32'h2);
        expect_reg(A_STAT, 1, "R6 bit1 only ignored");
        bus_write(A_STAT, 32'hFFFF_FFFF);
        expect_reg(A_STAT, 0, "R6 clear");

        // R7 sticky done across a new burst
        bus_write(A_CNT, 1);
        repeat (2 * DIV) @(negedge clk);
        expect_reg(A_STAT, 1, "R7 done after first");
        bus_write(A_CNT, 4);
        @(negedge clk);
        expect_reg(A_STAT, 3, "R7 done kept while busy");
        repeat (2 * DIV * 4) @(negedge clk);
        expect_reg(A_STAT, 1, "R7 done after second");

        // R9 count write during a burst
        bus_write(A_STAT, 32'h1);
        r0 = rises;
        bus_write(A_CNT, 5);
        repeat (3) @(negedge clk);
        bus_write(A_CNT, 9);
        expect_reg(A_CNT, 5, "R9 count readback kept");
        repeat (2 * DIV * 5 - 6) @(negedge clk);
        expect_reg(A_STAT, 2, "R9 still busy at original end-1");
        expect_reg(A_STAT, 1, "R9 done at original time");
        chk(rises - r0 == 5, "R9 pulse count", rises - r0, 5);
        repeat (20) @(negedge clk);
        chk(rises - r0 == 5, "R9 no late pulses", rises - r0, 5);

        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule